// File: doc/BRIEF.md
# Biphasic Electrode Stimulus Sequencer

This block is the timing controller for a grid of stimulation sites laid out as rows and columns (10 x 10 by default). Each row is fed by one shared current source, and that source reaches the sites of its row through a demultiplexer. The block generates the phase strobes that an external analog waveform generator turns into current. It also generates the demultiplexer select code for every source and one gate line per site. The analog side sets amplitude and shape. This block sets only when each phase happens and where the current goes.

A start strobe latches the configuration: the phase width, the interphase gap, the slot period, the number of pulses and the site mask. Each pulse is one sweep over the columns in ascending order. Every column that has at least one enabled site gets one slot. A slot begins with the cathodic phase, then the gap, then the anodic phase of the same width, then rest until the slot period ends. Within a slot, the source of row r drives only the site in that row and the slot's column, and only when that site's mask bit is set. Configurations that cannot give a charge-balanced, well-formed train are refused and flagged.

Top module: `stim_pulse_seq`

## Requirements
- R1: After reset, busy_o, cfg_err_o, cath_o, anod_o, every src_en_o bit and every gate_o bit are 0, and every select field is 0.
- R2: A start_i seen while idle with a valid configuration sets busy_o in the next cycle. That same cycle is the first cycle of the first slot, and cath_o is high in it.
- R3: In each slot, cath_o is high for cycles 0..W-1, where W is the phase width. Neither strobe is high for the next G cycles, where G is the gap. anod_o is high for the W cycles after that. Both strobes are low for the rest of the slot, which lasts exactly P cycles in total, where P is the period.
- R4: A pulse visits the columns in ascending order. A column with no enabled site in any row is skipped and gets no slot. The mask bit of row r, column c is site_mask_i[r*COLS+c].
- R5: While busy, the select field of every source, src_sel_o[r*4 +: 4], holds the column number of the current slot. While idle it holds 0.
- R6: gate_o[r*COLS+c] and src_en_o[r] are high only during the cathodic or anodic phase of the slot for column c, and only when that site's mask bit is set. A source never has more than one gate high.
- R7: After the last slot of pulse number N (N = pulses_i), busy_o falls at once, and all gates and strobes are low.
- R8: start_i and all configuration inputs have no effect while busy_o is high. The running train keeps the configuration latched at its start.
- R9: A start is refused when any of these holds: the phase width is 0, the pulse count is 0, the mask is all zero, or the period is less than 2*W+G. When refused, busy_o stays low and cfg_err_o is high from the next cycle. cfg_err_o holds its value until the next start seen while idle, and an accepted start clears it.
- R10: With a gap of 0, anod_o rises in the cycle directly after the last cathodic cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| phase_w_i | input | 16 | Width of each phase in clock cycles |
| gap_w_i | input | 16 | Interphase gap in clock cycles |
| period_i | input | 16 | Slot length in clock cycles |
| pulses_i | input | 8 | Number of sweeps over the columns |
| site_mask_i | input | 100 | Per-site enable, bit r*COLS+c |
| busy_o | output | 1 | Train in progress |
| cfg_err_o | output | 1 | Last start attempt was refused |
| cath_o | output | 1 | Cathodic phase strobe |
| anod_o | output | 1 | Anodic phase strobe |
| src_sel_o | output | 40 | Demultiplexer select, 4 bits per source |
| src_en_o | output | 10 | Source r drives a site this cycle |
| gate_o | output | 100 | Per-site gate |

## Verification
Two events can fall in the same cycle: a start strobe that arrives while a train is running, and the end of a slot, when the column advances and the pulse count is consumed. The bench raises start_i with scrambled configuration inputs at chosen cycle offsets, some of them on the final cycle of a slot. It then compares every later cycle against a model built only from the configuration latched at the start. Any shift in the column order, the phase timing or the moment busy_o falls shows that the stray strobe was not ignored.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;
   typedef enum logic [1:0] {
      PH_CATH = 2'd0,
      PH_GAP  = 2'd1,
      PH_ANOD = 2'd2,
      PH_REST = 2'd3
   } phase_e;
endpackage

// File: rtl/stim_cfg_check.sv
module stim_cfg_check #(
   parameter int TW = 16,
   parameter int CW = 8
) (
   input  logic [TW-1:0] pw,
   input  logic [TW-1:0] gap,
   input  logic [TW-1:0] per,
   input  logic [CW-1:0] cnt,
   input  logic          any_site,
   output logic          ok
);
   localparam int EW = TW + 2;
   logic [EW-1:0] need;

   // a slot must hold both phases and the gap
   assign need = EW'(pw) + EW'(pw) + EW'(gap);
   assign ok   = (pw != '0) && (cnt != '0) && any_site && (EW'(per) >= need);
endmodule

// File: rtl/stim_slot_timer.sv
module stim_slot_timer
   import stim_seq_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          clr,
   input  logic [TW-1:0] pw,
   input  logic [TW-1:0] gap,
   input  logic [TW-1:0] per,
   output phase_e        phase,
   output logic          slot_end
);
   localparam int EW = TW + 2;
   logic [TW-1:0] tick;
   logic [EW-1:0] t_ext, end_cath, end_gap, end_anod;

   assign t_ext    = EW'(tick);
   assign end_cath = EW'(pw);
   assign end_gap  = end_cath + EW'(gap);
   assign end_anod = end_gap + EW'(pw);
   assign slot_end = run && (tick == per - TW'(1));

   always_comb begin
      if (t_ext < end_cath)      phase = PH_CATH;
      else if (t_ext < end_gap)  phase = PH_GAP;
      else if (t_ext < end_anod) phase = PH_ANOD;
      else                       phase = PH_REST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tick <= '0;
      else if (clr)      tick <= '0;
      else if (slot_end) tick <= '0;
      else if (run)      tick <= tick + TW'(1);
   end
endmodule

// File: rtl/stim_col_picker.sv
module stim_col_picker #(
   parameter int ROWS = 10,
   parameter int COLS = 10,
   parameter int SELW = 4
) (
   input  logic [ROWS*COLS-1:0] mask,
   input  logic [SELW-1:0]      cur,
   input  logic                 restart,
   output logic [SELW-1:0]      nxt,
   output logic                 wrap
);
   logic [COLS-1:0] col_used;
   logic [SELW-1:0] first_c, later_c;
   logic            found;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [ROWS-1:0] bits;
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign bits[r] = mask[r*COLS + c];
      end
      assign col_used[c] = |bits;
   end

   always_comb begin
      first_c = '0;
      later_c = '0;
      found   = 1'b0;
      for (int c = COLS - 1; c >= 0; c--) begin
         if (col_used[c]) begin
            first_c = SELW'(c);
            if (restart || (c > int'(cur))) begin
               later_c = SELW'(c);
               found   = 1'b1;
            end
         end
      end
      nxt  = found ? later_c : first_c;
      wrap = !found;
   end
endmodule

// File: rtl/stim_router.sv
module stim_router #(
   parameter int ROWS = 10,
   parameter int COLS = 10,
   parameter int SELW = 4
) (
   input  logic [ROWS*COLS-1:0] mask,
   input  logic [SELW-1:0]      col,
   input  logic                 drive,
   input  logic                 busy,
   output logic [ROWS*SELW-1:0] src_sel,
   output logic [ROWS-1:0]      src_en,
   output logic [ROWS*COLS-1:0] gate
);
   for (genvar r = 0; r < ROWS; r++) begin : g_src
      logic [COLS-1:0] row_m;
      assign row_m                   = mask[r*COLS +: COLS];
      assign src_sel[r*SELW +: SELW] = busy ? col : '0;
      assign src_en[r]               = drive && row_m[col];
      for (genvar c = 0; c < COLS; c++) begin : g_site
         assign gate[r*COLS + c] = drive && (col == SELW'(c)) && row_m[c];
      end
   end
endmodule

// File: rtl/stim_pulse_seq.sv
module stim_pulse_seq
   import stim_seq_pkg::*;
#(
   parameter int ROWS = 10,
   parameter int COLS = 10,
   parameter int TW   = 16,
   parameter int CW   = 8,
   localparam int NSITE = ROWS * COLS,
   localparam int SELW  = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [TW-1:0]        phase_w_i,
   input  logic [TW-1:0]        gap_w_i,
   input  logic [TW-1:0]        period_i,
   input  logic [CW-1:0]        pulses_i,
   input  logic [NSITE-1:0]     site_mask_i,
   output logic                 busy_o,
   output logic                 cfg_err_o,
   output logic                 cath_o,
   output logic                 anod_o,
   output logic [ROWS*SELW-1:0] src_sel_o,
   output logic [ROWS-1:0]      src_en_o,
   output logic [NSITE-1:0]     gate_o
);
   if (ROWS < 1) begin : g_bad_rows
      $error("stim_pulse_seq: ROWS must be at least 1");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("stim_pulse_seq: COLS must be at least 2");
   end
   if (TW < 2 || CW < 1) begin : g_bad_width
      $error("stim_pulse_seq: counter widths too small");
   end

   logic [TW-1:0]    pw_q, gap_q, per_q;
   logic [CW-1:0]    left_q;
   logic [NSITE-1:0] mask_q;
   logic [SELW-1:0]  col_q;
   logic             busy_q, err_q;

   logic            cfg_ok, in_empty, accept, attempt;
   logic [SELW-1:0] first_col, next_col;
   logic            sweep_done, slot_end, drive;
   phase_e          phase;

   assign attempt = start_i && !busy_q;
   assign accept  = attempt && cfg_ok;

   stim_col_picker #(.ROWS(ROWS), .COLS(COLS), .SELW(SELW)) u_pick_in (
      .mask    (site_mask_i),
      .cur     ('0),
      .restart (1'b1),
      .nxt     (first_col),
      .wrap    (in_empty)
   );

   stim_cfg_check #(.TW(TW), .CW(CW)) u_cfg (
      .pw       (phase_w_i),
      .gap      (gap_w_i),
      .per      (period_i),
      .cnt      (pulses_i),
      .any_site (!in_empty),
      .ok       (cfg_ok)
   );

   stim_col_picker #(.ROWS(ROWS), .COLS(COLS), .SELW(SELW)) u_pick_run (
      .mask    (mask_q),
      .cur     (col_q),
      .restart (1'b0),
      .nxt     (next_col),
      .wrap    (sweep_done)
   );

   stim_slot_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy_q),
      .clr      (accept),
      .pw       (pw_q),
      .gap      (gap_q),
      .per      (per_q),
      .phase    (phase),
      .slot_end (slot_end)
   );

   assign drive = busy_q && ((phase == PH_CATH) || (phase == PH_ANOD));

   stim_router #(.ROWS(ROWS), .COLS(COLS), .SELW(SELW)) u_route (
      .mask    (mask_q),
      .col     (col_q),
      .drive   (drive),
      .busy    (busy_q),
      .src_sel (src_sel_o),
      .src_en  (src_en_o),
      .gate    (gate_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         pw_q   <= '0;
         gap_q  <= '0;
         per_q  <= '0;
         left_q <= '0;
         mask_q <= '0;
         col_q  <= '0;
      end else if (attempt) begin
         err_q <= !cfg_ok;
         if (cfg_ok) begin
            busy_q <= 1'b1;
            pw_q   <= phase_w_i;
            gap_q  <= gap_w_i;
            per_q  <= period_i;
            left_q <= pulses_i;
            mask_q <= site_mask_i;
            col_q  <= first_col;
         end
      end else if (slot_end) begin
         col_q <= next_col;
         if (sweep_done) begin
            left_q <= left_q - CW'(1);
            if (left_q == CW'(1)) begin
               busy_q <= 1'b0;
               col_q  <= '0;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign cfg_err_o = err_q;
   assign cath_o    = busy_q && (phase == PH_CATH);
   assign anod_o    = busy_q && (phase == PH_ANOD);
endmodule

// File: rtl/stim_pulse_seq_chk.sv
module stim_pulse_seq_chk #(
   parameter int ROWS = 10,
   parameter int COLS = 10,
   parameter int TW   = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic [TW-1:0]        phase_w_i,
   input logic                 busy_o,
   input logic                 cfg_err_o,
   input logic                 cath_o,
   input logic                 anod_o,
   input logic [ROWS-1:0]      src_en_o,
   input logic [ROWS*COLS-1:0] gate_o
);
   // R3
   phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cath_o && anod_o));

   // R6
   gate_needs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|gate_o) |-> (cath_o || anod_o));

   // R2
   busy_rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R9
   zero_width_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && (phase_w_i == '0)) |=> (!busy_o && cfg_err_o));

   // R8
   start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(cfg_err_o));

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      // R6
      one_gate_per_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gate_o[r*COLS +: COLS]));
      // R6
      src_en_gate_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
         src_en_o[r] == (|gate_o[r*COLS +: COLS]));
   end
endmodule

bind stim_pulse_seq stim_pulse_seq_chk #(.ROWS(ROWS), .COLS(COLS), .TW(TW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .phase_w_i (phase_w_i),
   .busy_o    (busy_o),
   .cfg_err_o (cfg_err_o),
   .cath_o    (cath_o),
   .anod_o    (anod_o),
   .src_en_o  (src_en_o),
   .gate_o    (gate_o)
);

// File: tb/stim_pulse_seq_bench.sv
module stim_pulse_seq_bench;
   localparam int ROWS = 10;
   localparam int COLS = 10;
   localparam int TW   = 16;
   localparam int CW   = 8;
   localparam int NS   = ROWS * COLS;
   localparam int SELW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [TW-1:0] phase_w_i = '0, gap_w_i = '0, period_i = '0;
   logic [CW-1:0] pulses_i = '0;
   logic [NS-1:0] site_mask_i = '0;
   logic busy_o, cfg_err_o, cath_o, anod_o;
   logic [ROWS*SELW-1:0] src_sel_o;
   logic [ROWS-1:0] src_en_o;
   logic [NS-1:0] gate_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   stim_pulse_seq #(.ROWS(ROWS), .COLS(COLS), .TW(TW), .CW(CW)) u_stim_pulse_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_w_i(phase_w_i),
      .gap_w_i(gap_w_i), .period_i(period_i), .pulses_i(pulses_i),
      .site_mask_i(site_mask_i), .busy_o(busy_o), .cfg_err_o(cfg_err_o),
      .cath_o(cath_o), .anod_o(anod_o), .src_sel_o(src_sel_o),
      .src_en_o(src_en_o), .gate_o(gate_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit col_used(input logic [NS-1:0] m, input int c);
      bit u = 1'b0;
      for (int r = 0; r < ROWS; r++) u |= m[r*COLS + c];
      return u;
   endfunction

   function automatic logic [NS-1:0] exp_gate(input logic [NS-1:0] m, input int c,
                                              input bit drv);
      logic [NS-1:0] g = '0;
      for (int r = 0; r < ROWS; r++) g[r*COLS + c] = drv && m[r*COLS + c];
      return g;
   endfunction

   function automatic logic [ROWS-1:0] exp_en(input logic [NS-1:0] m, input int c,
                                              input bit drv);
      logic [ROWS-1:0] e = '0;
      for (int r = 0; r < ROWS; r++) e[r] = drv && m[r*COLS + c];
      return e;
   endfunction

   function automatic logic [ROWS*SELW-1:0] exp_sel(input int c);
      logic [ROWS*SELW-1:0] s = '0;
      for (int r = 0; r < ROWS; r++) s[r*SELW +: SELW] = SELW'(c);
      return s;
   endfunction

   // runs one train; at cycle index inj a stray start with junk config is raised
   task automatic run_case(input int pw, input int gp, input int per, input int cnt,
                           input logic [NS-1:0] m, input int inj);
      int idx = 0;
      phase_w_i = TW'(pw); gap_w_i = TW'(gp); period_i = TW'(per);
      pulses_i = CW'(cnt); site_mask_i = m;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R2 busy after start", 128'(busy_o), 128'(1));
      chk(cfg_err_o === 1'b0, "R9 error cleared", 128'(cfg_err_o), 128'(0));
      for (int p = 0; p < cnt; p++) begin
         for (int c = 0; c < COLS; c++) begin
            if (!col_used(m, c)) continue;
            for (int t = 0; t < per; t++) begin
               bit ec = (t < pw);
               bit ea = (t >= pw + gp) && (t < 2 * pw + gp);
               chk(cath_o === ec, "R2 R3 cathodic strobe", 128'(cath_o), 128'(ec));
               chk(anod_o === ea, "R3 anodic strobe", 128'(anod_o), 128'(ea));
               if (gp == 0 && t == pw)
                  chk(anod_o === 1'b1, "R10 no-gap anodic", 128'(anod_o), 128'(1));
               chk(gate_o === exp_gate(m, c, ec || ea), "R4 R6 site gates",
                   128'(gate_o), 128'(exp_gate(m, c, ec || ea)));
               chk(src_en_o === exp_en(m, c, ec || ea), "R6 source enables",
                   128'(src_en_o), 128'(exp_en(m, c, ec || ea)));
               chk(src_sel_o === exp_sel(c), "R5 select codes",
                   128'(src_sel_o), 128'(exp_sel(c)));
               chk(busy_o === 1'b1, "R7 busy during train", 128'(busy_o), 128'(1));
               if (idx == inj) begin
                  // R8: stray start and junk config while busy
                  start_i = 1'b1;
                  phase_w_i = TW'($urandom_range(0, 9));
                  gap_w_i = TW'($urandom_range(0, 9));
                  period_i = TW'($urandom_range(0, 30));
                  pulses_i = CW'($urandom_range(0, 5));
                  site_mask_i = {$urandom(), $urandom(), $urandom(), $urandom()};
               end else begin
                  start_i = 1'b0;
               end
               idx++;
               @(negedge clk);
            end
         end
      end
      start_i = 1'b0;
      chk(busy_o === 1'b0, "R7 busy falls after last slot", 128'(busy_o), 128'(0));
      chk(gate_o === '0 && !cath_o && !anod_o, "R7 outputs quiet", 128'(gate_o), 128'(0));
      chk(cfg_err_o === 1'b0, "R8 stray start left no error", 128'(cfg_err_o), 128'(0));
      @(negedge clk);
   endtask

   task automatic bad_case(input int pw, input int gp, input int per, input int cnt,
                           input logic [NS-1:0] m, input string why);
      phase_w_i = TW'(pw); gap_w_i = TW'(gp); period_i = TW'(per);
      pulses_i = CW'(cnt); site_mask_i = m;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b0, {"R9 refused busy ", why}, 128'(busy_o), 128'(0));
      chk(cfg_err_o === 1'b1, {"R9 error flag ", why}, 128'(cfg_err_o), 128'(1));
      @(negedge clk);
      chk(cfg_err_o === 1'b1, {"R9 error held ", why}, 128'(cfg_err_o), 128'(1));
   endtask

   function automatic logic [NS-1:0] rand_mask();
      logic [NS-1:0] m = '0;
      for (int c = 0; c < COLS; c++)
         if ($urandom_range(0, 2) == 0)
            for (int r = 0; r < ROWS; r++) m[r*COLS + c] = 1'($urandom_range(0, 1));
      if (m == '0) m[$urandom_range(0, NS - 1)] = 1'b1;
      return m;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NS-1:0] m;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy_o === 1'b0 && cfg_err_o === 1'b0, "R1 busy/error at reset",
          128'({busy_o, cfg_err_o}), 128'(0));
      chk(!cath_o && !anod_o && gate_o === '0 && src_en_o === '0 && src_sel_o === '0,
          "R1 outputs at reset", 128'(gate_o), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // directed: a single site, minimum widths, period exactly full
      m = '0; m[0] = 1'b1;
      run_case(1, 0, 2, 1, m, -1);
      // directed: column 0 and last column, gap 0, stray start on a slot end
      m = '0; m[3*COLS + 0] = 1'b1; m[7*COLS + COLS - 1] = 1'b1; m[9*COLS + COLS - 1] = 1'b1;
      run_case(2, 0, 6, 2, m, 5);
      // directed: skipped columns, stray start in the first cycle
      m = '0; m[1*COLS + 2] = 1'b1; m[4*COLS + 5] = 1'b1; m[4*COLS + 8] = 1'b1;
      run_case(3, 2, 10, 2, m, 0);

      // refused configurations
      m = '0; m[5] = 1'b1;
      bad_case(0, 1, 8, 1, m, "zero width");
      bad_case(2, 1, 8, 0, m, "zero count");
      bad_case(2, 1, 8, 1, '0, "empty mask");
      bad_case(3, 2, 7, 1, m, "short period");
      run_case(3, 2, 8, 1, m, 3);

      // constrained random trains
      for (int i = 0; i < 12; i++) begin
         int pw = $urandom_range(1, 4);
         int gp = $urandom_range(0, 3);
         int per = 2 * pw + gp + $urandom_range(0, 4);
         int cnt = $urandom_range(1, 3);
         run_case(pw, gp, per, cnt, rand_mask(), $urandom_range(0, 40));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule